// File: doc/BRIEF.md
# Dual-Select Byte-Lane Static RAM Model

This block is a synthesizable functional stand-in for a 16-bit-wide asynchronous static RAM. It is meant to be placed in a test harness opposite a memory controller. Two chip selects of opposite polarity gate the device. Output enable and write enable are active low. The lower and upper data bytes each have their own active-low lane enable. From these pins the block decodes one of five states: deselected, no lane enabled, output disabled, read and write. In the read state it drives only the lanes that are enabled. In the write state it updates only those lanes.

The bidirectional data bus is split into three parts: a write-data input, a read-data output and one drive-enable bit per byte lane. The harness, or an FPGA pad, builds the tri-state buffer from these. Reads are combinational from the address and the pins. Writes are approximated on a sampling clock. While the write condition holds, the block captures address, data and lane mask on every clock edge. The values from the last such edge are stored when the write condition ends, whichever pin ends it. Storage contents are undefined after power-up. The address width is a parameter: 16 bits gives the full 65,536 words, and the default build is smaller.

Top module: `dualsel_sram`

## Requirements
- R1: The device is selected only when `sel_n` is 0 and `sel_p` is 1. In every other combination `lane_drv` is 2'b00 and no write takes effect, even with `we_n` low and both lane enables low.
- R2: When selected with `lo_en_n` and `hi_en_n` both 1, `lane_drv` is 2'b00 for every value of `oe_n` and `we_n`, and a write attempt changes no stored byte.
- R3: When selected with a lane enabled, `oe_n` = 1 and `we_n` = 1, `lane_drv` is 2'b00.
- R4: When selected with `oe_n` = 0 and `we_n` = 1, `lane_drv[0]` equals NOT `lo_en_n` and `lane_drv[1]` equals NOT `hi_en_n` in the same cycle as the pins. The stored lower byte appears on `rdata[7:0]` and the stored upper byte on `rdata[15:8]`.
- R5: While `we_n` is 0, `lane_drv` is 2'b00 whatever the value of `oe_n`.
- R6: A write updates only the byte lanes whose enable is 0. The other lane of the same word keeps its old value.
- R7: A write ends at the first clock edge where the write condition no longer holds. The write condition is: selected, `we_n` 0, and at least one lane enabled. The write can be ended by `sel_n` or by `we_n`. The word stored is the `wdata` sampled at the last edge at which the condition held. Data changed after the end has no effect. The new value is readable once that ending edge has passed.
- R8: The address and lane mask used by a write are those sampled at the last edge at which the write condition held. An address seen earlier in the same write interval is not modified.
- R9: While `rst` is 1, `lane_drv` is 2'b00. A write interval that is still open when `rst` rises is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the write path |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select |
| sel_p | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| lo_en_n | input | 1 | Active-low lower byte lane enable (bits 7..0) |
| hi_en_n | input | 1 | Active-low upper byte lane enable (bits 15..8) |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data from the bus |
| rdata | output | 16 | Read data toward the bus |
| lane_drv | output | 2 | Per-lane drive enable: bit 0 lower byte, bit 1 upper byte |

## Verification
Drive enables and read data are combinational, so the bench checks them two nanoseconds after it changes the pins, and always before the next rising edge. A write takes effect on the edge at which the write condition is first seen inactive. The bench therefore sets the ending pin at a falling edge and changes `wdata` in the same step. It reads back only after one further idle cycle, so the commit edge has passed. Expected bytes come from a bench-side copy of the memory. That copy is updated only through the lane mask and address of the final active cycle, which lets address changes in mid-write, zero data hold and discarded writes all be compared against it.

// File: rtl/dualsel_sram_pkg.sv
package dualsel_sram_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic [2:0] {
        M_DESEL,
        M_NOLANE,
        M_OUTOFF,
        M_READ,
        M_WRITE
    } mode_e;

    typedef struct packed {
        logic sel_n;
        logic sel_p;
        logic oe_n;
        logic we_n;
        logic [LANES-1:0] en_n;
    } pins_t;

    // Priority: reset/deselect, then lane enables, then write, then output enable.
    function automatic mode_e decode_mode(input logic rst, input pins_t p);
        if (rst || p.sel_n || !p.sel_p) return M_DESEL;
        if (&p.en_n)                    return M_NOLANE;
        if (!p.we_n)                    return M_WRITE;
        if (p.oe_n)                     return M_OUTOFF;
        return M_READ;
    endfunction

endpackage

// File: rtl/dualsel_decode.sv
module dualsel_decode
    import dualsel_sram_pkg::*;
(
    input  logic             rst,
    input  pins_t            pins,
    output logic [LANES-1:0] drv,
    output logic [LANES-1:0] wr_mask
);
    mode_e mode;

    always_comb begin
        mode    = decode_mode(rst, pins);
        drv     = '0;
        wr_mask = '0;
        case (mode)
            M_READ:  drv     = ~pins.en_n;
            M_WRITE: wr_mask = ~pins.en_n;
            default: ;
        endcase
    end
endmodule

// File: rtl/dualsel_write_capture.sv
module dualsel_write_capture
    import dualsel_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              commit,
    output logic [ADDR_W-1:0] c_addr,
    output logic [WORD_W-1:0] c_data,
    output logic [LANES-1:0]  c_mask
);
    logic active, active_q;

    assign active = |wr_mask;
    // The write closes on the first edge where the condition is gone.
    assign commit = active_q && !active && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            c_addr   <= '0;
            c_data   <= '0;
            c_mask   <= '0;
        end else begin
            active_q <= active;
            if (active) begin
                c_addr <= addr;
                c_data <= wdata;
                c_mask <= wr_mask;
            end
        end
    end
endmodule

// File: rtl/dualsel_lane_array.sv
module dualsel_lane_array
    import dualsel_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              commit,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [WORD_W-1:0] c_data,
    input  logic [LANES-1:0]  c_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (commit && c_mask[g])
                store[c_addr] <= c_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = store[rd_addr];
    end
endmodule

// File: rtl/dualsel_sram.sv
module dualsel_sram
    import dualsel_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sel_p,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lo_en_n,
    input  logic              hi_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic [1:0]        lane_drv
);
    pins_t             pins;
    logic [LANES-1:0]  wr_mask;
    logic              commit_w;
    logic [ADDR_W-1:0] c_addr;
    logic [WORD_W-1:0] c_data;
    logic [LANES-1:0]  c_mask;

    assign pins = '{sel_n: sel_n, sel_p: sel_p, oe_n: oe_n, we_n: we_n,
                    en_n: {hi_en_n, lo_en_n}};

    dualsel_decode u_dec (
        .rst     (rst),
        .pins    (pins),
        .drv     (lane_drv),
        .wr_mask (wr_mask)
    );

    dualsel_write_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .wr_mask (wr_mask),
        .addr    (addr),
        .wdata   (wdata),
        .commit  (commit_w),
        .c_addr  (c_addr),
        .c_data  (c_data),
        .c_mask  (c_mask)
    );

    dualsel_lane_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .commit  (commit_w),
        .c_addr  (c_addr),
        .c_data  (c_data),
        .c_mask  (c_mask),
        .rd_addr (addr),
        .rd_data (rdata)
    );
endmodule

// File: rtl/dualsel_sram_checker.sv
module dualsel_sram_checker (
    input logic       clk,
    input logic       rst,
    input logic       sel_n,
    input logic       sel_p,
    input logic       oe_n,
    input logic       we_n,
    input logic       lo_en_n,
    input logic       hi_en_n,
    input logic [1:0] lane_drv,
    input logic       commit
);
    a_r1_desel_floats: assert property (@(posedge clk) disable iff (rst)
        (sel_n || !sel_p) |-> (lane_drv == 2'b00));

    a_r2_no_lane_floats: assert property (@(posedge clk) disable iff (rst)
        (lo_en_n && hi_en_n) |-> (lane_drv == 2'b00));

    a_r3_outoff_floats: assert property (@(posedge clk) disable iff (rst)
        (oe_n && we_n) |-> (lane_drv == 2'b00));

    a_r4_lane_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (lane_drv[0] |-> !lo_en_n) and (lane_drv[1] |-> !hi_en_n));

    a_r5_write_floats: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (lane_drv == 2'b00));

    // R7: a store happens only once the write condition is gone at the pins,
    // and only right after a cycle in which it held.
    a_r7_commit_at_end: assert property (@(posedge clk) disable iff (rst)
        commit |-> !(!sel_n && sel_p && !we_n && !(lo_en_n && hi_en_n)));

    a_r7_commit_after_write: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(!sel_n && sel_p && !we_n && !(lo_en_n && hi_en_n)));
endmodule

bind dualsel_sram dualsel_sram_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (sel_n),
    .sel_p    (sel_p),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .lo_en_n  (lo_en_n),
    .hi_en_n  (hi_en_n),
    .lane_drv (lane_drv),
    .commit   (commit_w)
);

// File: tb/test_dualsel_sram.sv
module test_dualsel_sram;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n, sel_p, oe_n, we_n, lo_en_n, hi_en_n;
    logic [AW-1:0] addr;
    logic [15:0]   wdata;
    logic [15:0]   rdata;
    logic [1:0]    lane_drv;

    always #4 clk = ~clk;

    dualsel_sram #(.ADDR_W(AW)) i_dualsel_sram (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sel_p(sel_p), .oe_n(oe_n),
        .we_n(we_n), .lo_en_n(lo_en_n), .hi_en_n(hi_en_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lane_drv(lane_drv)
    );

    int          n_vec = 0;
    int          n_bad = 0;
    logic [15:0] ref_mem [DEPTH];

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic go_idle();
        sel_n = 1'b1; sel_p = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        lo_en_n = 1'b1; hi_en_n = 1'b1;
    endtask

    // Expected word after a masked write.
    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] m);
        return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
    endfunction

    // Two active cycles (address a0 then a1), then ended by sel_n or we_n.
    task automatic do_write(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                            input logic [15:0] d, input logic [1:0] m,
                            input bit end_cs, input bit oe_low, input string req);
        @(negedge clk);
        sel_n = 1'b0; sel_p = 1'b1; we_n = 1'b0; oe_n = !oe_low;
        {hi_en_n, lo_en_n} = ~m; addr = a0; wdata = ~d;
        @(negedge clk);
        check({req, " drive during write"}, {14'd0, lane_drv}, 16'd0);
        addr = a1; wdata = d;
        @(negedge clk);
        check({req, " drive during write"}, {14'd0, lane_drv}, 16'd0);
        if (end_cs) sel_n = 1'b1; else we_n = 1'b1;
        wdata = 16'($urandom);
        @(negedge clk);
        go_idle();
        if (m != 2'b00) ref_mem[a1] = merge(ref_mem[a1], d, m);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] m, input string req);
        @(negedge clk);
        sel_n = 1'b0; sel_p = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        {hi_en_n, lo_en_n} = ~m; addr = a;
        #2;
        check({req, " lane drive"}, {14'd0, lane_drv}, {14'd0, m});
        if (m[0]) check({req, " low byte"},  {8'd0, rdata[7:0]},  {8'd0, ref_mem[a][7:0]});
        if (m[1]) check({req, " high byte"}, {8'd0, rdata[15:8]}, {8'd0, ref_mem[a][15:8]});
        @(negedge clk);
        go_idle();
    endtask

    // Write attempt with a bad select pair: nothing driven, nothing stored.
    task automatic bad_select_write(input logic [AW-1:0] a, input logic sn, input logic sp);
        @(negedge clk);
        sel_n = sn; sel_p = sp; we_n = 1'b0; oe_n = 1'b0;
        lo_en_n = 1'b0; hi_en_n = 1'b0; addr = a; wdata = ~ref_mem[a];
        #2;
        check("R1 deselected drive", {14'd0, lane_drv}, 16'd0);
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        go_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual running expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        go_idle();
        addr = '0; wdata = '0;
        // R9: read pins asserted under reset, nothing driven
        repeat (2) @(negedge clk);
        sel_n = 1'b0; sel_p = 1'b1; oe_n = 1'b0; lo_en_n = 1'b0; hi_en_n = 1'b0;
        #2;
        check("R9 drive in reset", {14'd0, lane_drv}, 16'd0);
        @(negedge clk);
        go_idle(); rst = 1'b0;

        // Fill a working window of 32 words, alternating the ending pin (R7)
        for (int a = 0; a < 32; a++)
            do_write(AW'(a), AW'(a), 16'(a * 16'h0101) ^ 16'h5a3c, 2'b11, a[0], 1'b0, "R7");
        for (int a = 0; a < 32; a++)
            do_read(AW'(a), 2'b11, "R4 word read");

        // R6 byte writes
        do_write(AW'(4), AW'(4), 16'hc0de, 2'b01, 1'b0, 1'b0, "R6");
        do_read(AW'(4), 2'b11, "R6 lower only");
        do_write(AW'(5), AW'(5), 16'hbeef, 2'b10, 1'b1, 1'b0, "R6");
        do_read(AW'(5), 2'b11, "R6 upper only");
        do_read(AW'(5), 2'b01, "R4 lower read");
        do_read(AW'(5), 2'b10, "R4 upper read");

        // R5 write with output enable low
        do_write(AW'(6), AW'(6), 16'h1234, 2'b11, 1'b0, 1'b1, "R5");
        do_read(AW'(6), 2'b11, "R5 readback");

        // R8 address moves inside one write interval
        do_write(AW'(7), AW'(9), 16'h9a9a, 2'b11, 1'b0, 1'b0, "R8");
        do_read(AW'(7), 2'b11, "R8 first address untouched");
        do_read(AW'(9), 2'b11, "R8 final address written");

        // R1 bad select pairs
        bad_select_write(AW'(10), 1'b1, 1'b1);
        bad_select_write(AW'(10), 1'b0, 1'b0);
        bad_select_write(AW'(10), 1'b1, 1'b0);
        do_read(AW'(10), 2'b11, "R1 no write when deselected");

        // R2 no lane enabled
        do_write(AW'(11), AW'(11), 16'hdead, 2'b00, 1'b0, 1'b0, "R2");
        do_read(AW'(11), 2'b11, "R2 no write without lanes");
        @(negedge clk);
        sel_n = 1'b0; sel_p = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        #2;
        check("R2 drive without lanes", {14'd0, lane_drv}, 16'd0);

        // R3 output disabled
        @(negedge clk);
        oe_n = 1'b1; lo_en_n = 1'b0; hi_en_n = 1'b0;
        #2;
        check("R3 output disabled drive", {14'd0, lane_drv}, 16'd0);
        @(negedge clk);
        go_idle();

        // R9 reset in the middle of an open write discards it
        @(negedge clk);
        sel_n = 1'b0; sel_p = 1'b1; we_n = 1'b0; lo_en_n = 1'b0; hi_en_n = 1'b0;
        addr = AW'(12); wdata = 16'h0bad;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        go_idle(); rst = 1'b0;
        do_read(AW'(12), 2'b11, "R9 write discarded by reset");

        // Random mix over the working window
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] ra;
            logic [1:0]    rm;
            int            op;
            ra = AW'($urandom_range(0, 31));
            rm = 2'($urandom);
            op = $urandom_range(0, 3);
            case (op)
                0: do_write(ra, ra, 16'($urandom), rm, 1'($urandom), 1'($urandom), "R6 random");
                1: do_write(AW'($urandom_range(0, 31)), ra, 16'($urandom), rm,
                            1'($urandom), 1'b0, "R8 random");
                2: bad_select_write(ra, 1'b1, 1'($urandom));
                default: do_read(ra, rm, "R4 random");
            endcase
        end
        for (int a = 0; a < 32; a++)
            do_read(AW'(a), 2'b11, "R6 final sweep");

        summary();
    end
endmodule